// File: doc/BRIEF.md
# Codec Serial Control Writer

This block delivers single register writes to one of two audio codec devices over a three-wire, write-only control port: a serial data line, a serial clock and one active-low select per codec. A write request carries a codec index, a 5-bit register address and an 8-bit value and is handed over through a valid/ready pair. The block packs the request into a 16-bit word, prefixes it with a fixed device code and a write marker, and shifts it out most significant bit first.

Every change on the port is followed by a settle interval of `SETTLE_CYCLES` system clocks, so the slow control port can be driven straight from a fast core clock. While a word is on its way, `busy_o` is high and `req_ready_o` is low; requests offered in that time are not taken.

Top module: `codec_ctl_writer`

## Requirements
- R1: The transmitted word is 16 bits: bits 15:14 hold the device code 2'b10, bit 13 is always 1, bits 12:8 hold the register address and bits 7:0 hold the data byte.
- R2: The word is sent starting at bit 15 and ending at bit 0, one bit per rising edge of `sclk_o`, giving exactly 16 rising edges while a select is low.
- R3: For each bit the clock is first driven low, then the data line takes the bit, then the clock is driven high; the data line never changes while a select is low and the clock is high.
- R4: While idle, `sdata_o`, `sclk_o` and both bits of `cs_n_o` are high; after a request is taken they remain high for one full settle interval before a select falls.
- R5: Codec index 0 pulls `cs_n_o[0]` low; any nonzero index pulls `cs_n_o[1]` low; at most one select is low at any time.
- R6: After bit 0 the data line, the clock and both selects return high together, and the block stays busy for exactly one further settle interval.
- R7: Every step lasts exactly `SETTLE_CYCLES` clocks: consecutive changes on the port are at least that far apart, and one word keeps `busy_o` high for 51 × `SETTLE_CYCLES` cycles.
- R8: A request is taken only in a cycle where `req_valid_i` and `req_ready_o` are both high; from the next cycle until the word ends `req_ready_o` is low and `busy_o` is high, and requests offered then have no effect.
- R9: An active-low asynchronous reset returns the port lines high, `busy_o` low and `req_ready_o` high, also in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Write request offered |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_idx_i | input | IDX_W | Codec index (0 selects codec 0, otherwise codec 1) |
| req_reg_i | input | 5 | Register address |
| req_data_i | input | 8 | Data byte |
| busy_o | output | 1 | A word is being sent |
| sdata_o | output | 1 | Serial data line |
| sclk_o | output | 1 | Serial clock line |
| cs_n_o | output | 2 | Active-low codec selects |

## Verification
All port lines are registers, so `busy_o` rises on the clock edge that takes a request, the first select edge follows `SETTLE_CYCLES` clocks later, the final release comes 50 × `SETTLE_CYCLES` clocks after acceptance and `busy_o` falls one interval after that. The bench samples every line on the falling clock edge, counts cycles between port changes, assembles the word on each rising `sclk_o`, and only compares the word, the select used and the busy length once it has seen `busy_o` low at a falling edge. Reset effects are sampled shortly after `rst_ni` falls, since the reset acts without a clock.

// File: rtl/ccw_pkg.sv
package ccw_pkg;
  localparam int FRAME_W = 16;
  localparam int REG_W   = 5;
  localparam int DATA_W  = 8;
  localparam int BIT_W   = $clog2(FRAME_W);
  localparam logic [1:0] DEV_CODE = 2'b10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,   // all high, settle
    ST_SEL,   // select low
    ST_CLO,   // clock low
    ST_DAT,   // data bit placed
    ST_CHI,   // clock high
    ST_REL    // everything released
  } step_e;
endpackage

// File: rtl/ccw_frame_build.sv
module ccw_frame_build
  import ccw_pkg::*;
(
  input  logic [REG_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [FRAME_W-1:0] frame_o
);
  assign frame_o = {DEV_CODE, 1'b1, reg_i, data_i};
endmodule

// File: rtl/ccw_settle_timer.sv
module ccw_settle_timer #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic done_o
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= LOAD_VAL;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/ccw_seq.sv
module ccw_seq
  import ccw_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [IDX_W-1:0]   req_idx_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tmr_done_i,
  output logic               tmr_load_o,
  output logic               req_ready_o,
  output logic               busy_o,
  output logic               sdata_o,
  output logic               sclk_o,
  output logic [1:0]         cs_n_o
);
  step_e              st_q;
  logic [FRAME_W-1:0] sh_q;
  logic [BIT_W-1:0]   bit_q;
  logic               sel_q;
  logic               sdata_q, sclk_q;
  logic [1:0]         cs_q;
  logic               accept, adv;

  assign accept     = req_valid_i && (st_q == ST_IDLE);
  assign adv        = (st_q != ST_IDLE) && tmr_done_i;
  assign tmr_load_o = accept || (adv && st_q != ST_REL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      sh_q    <= '0;
      bit_q   <= '0;
      sel_q   <= 1'b0;
      sdata_q <= 1'b1;
      sclk_q  <= 1'b1;
      cs_q    <= 2'b11;
    end else if (accept) begin
      st_q    <= ST_PRE;
      sh_q    <= frame_i;
      bit_q   <= BIT_W'(FRAME_W - 1);
      sel_q   <= (req_idx_i != '0);
      sdata_q <= 1'b1;
      sclk_q  <= 1'b1;
      cs_q    <= 2'b11;
    end else if (adv) begin
      unique case (st_q)
        ST_PRE: begin
          st_q        <= ST_SEL;
          cs_q[sel_q] <= 1'b0;
        end
        ST_SEL: begin
          st_q   <= ST_CLO;
          sclk_q <= 1'b0;
        end
        ST_CLO: begin
          st_q    <= ST_DAT;
          sdata_q <= sh_q[FRAME_W-1];
          sh_q    <= {sh_q[FRAME_W-2:0], 1'b0};
        end
        ST_DAT: begin
          st_q   <= ST_CHI;
          sclk_q <= 1'b1;
        end
        ST_CHI: begin
          if (bit_q == '0) begin
            st_q    <= ST_REL;
            sdata_q <= 1'b1;
            cs_q    <= 2'b11;
          end else begin
            st_q   <= ST_CLO;
            bit_q  <= bit_q - 1'b1;
            sclk_q <= 1'b0;
          end
        end
        ST_REL:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign busy_o      = (st_q != ST_IDLE);
  assign sdata_o     = sdata_q;
  assign sclk_o      = sclk_q;
  assign cs_n_o      = cs_q;

  // R5
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_q));

  // R3
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sdata_q) && cs_q != 2'b11 && $past(cs_q) != 2'b11) |-> !sclk_q);

  // R2
  clk_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) |-> cs_q != 2'b11);

  // R4
  idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (sdata_q && sclk_q && cs_q == 2'b11));

  // R8
  take_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (busy_o && !req_ready_o));

  // R7
  step_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE && !tmr_done_i) |=> st_q == $past(st_q));
endmodule

// File: rtl/codec_ctl_writer.sv
module codec_ctl_writer
  import ccw_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64,
  parameter int IDX_W         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [REG_W-1:0]  req_reg_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              busy_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic [1:0]        cs_n_o
);
  logic [FRAME_W-1:0] frame;
  logic               tmr_load, tmr_done;

  ccw_frame_build u_frame (
    .reg_i   (req_reg_i),
    .data_i  (req_data_i),
    .frame_o (frame)
  );

  ccw_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .done_o (tmr_done)
  );

  ccw_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_idx_i   (req_idx_i),
    .frame_i     (frame),
    .tmr_done_i  (tmr_done),
    .tmr_load_o  (tmr_load),
    .req_ready_o (req_ready_o),
    .busy_o      (busy_o),
    .sdata_o     (sdata_o),
    .sclk_o      (sclk_o),
    .cs_n_o      (cs_n_o)
  );
endmodule

// File: tb/codec_ctl_writer_tb.sv
`timescale 1ns/1ps
module codec_ctl_writer_tb;
  localparam int S = 3;
  localparam int NVEC = 6;
  // {idx[1:0], reg[4:0], data[7:0]}
  localparam logic [14:0] VEC [NVEC] = '{
    {2'd0, 5'h00, 8'h00}, {2'd1, 5'h1F, 8'hFF}, {2'd0, 5'h15, 8'hA5},
    {2'd2, 5'h0A, 8'h5A}, {2'd3, 5'h03, 8'h01}, {2'd0, 5'h10, 8'h80}};

  logic clk = 0, rst_ni = 0;
  logic req_valid = 0;
  logic [1:0] req_idx = 0;
  logic [4:0] req_reg = 0;
  logic [7:0] req_data = 0;
  logic ready, busy, sdata, sclk;
  logic [1:0] cs_n;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  codec_ctl_writer #(.SETTLE_CYCLES(S), .IDX_W(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_idx_i(req_idx), .req_reg_i(req_reg), .req_data_i(req_data),
    .busy_o(busy), .sdata_o(sdata), .sclk_o(sclk), .cs_n_o(cs_n));

  // monitor
  int cyc = 0, last_chg = 0, min_gap = 0, busy_cnt = 0, rises = 0, end_gap = 0;
  int frames_started = 0, bad_order = 0, both_low = 0;
  logic [15:0] cap = 0;
  logic [1:0] cs_seen = 0;
  logic p_busy = 0, p_sclk = 1, p_sdata = 1;
  logic [1:0] p_cs = 2'b11;

  always @(negedge clk) begin
    cyc++;
    if (busy && !p_busy) begin
      cap = 0; rises = 0; cs_seen = 0; busy_cnt = 0; min_gap = 1000;
      last_chg = cyc; bad_order = 0; both_low = 0; frames_started++;
    end
    if (busy) busy_cnt++;
    if (!busy && p_busy) end_gap = cyc - last_chg;
    if (sclk != p_sclk || sdata != p_sdata || cs_n != p_cs) begin
      if (cyc - last_chg < min_gap) min_gap = cyc - last_chg;
      last_chg = cyc;
    end
    if (sdata != p_sdata && cs_n != 2'b11 && p_cs != 2'b11 && sclk) bad_order++;
    if (sclk && !p_sclk && cs_n != 2'b11) begin cap = {cap[14:0], sdata}; rises++; end
    if (cs_n == 2'b00) both_low++;
    cs_seen |= ~cs_n;
    p_busy = busy; p_sclk = sclk; p_sdata = sdata; p_cs = cs_n;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [1:0] idx, input logic [4:0] rg, input logic [7:0] d);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1; req_idx = idx; req_reg = rg; req_data = d;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(posedge clk);
    while (p_busy && n < 2000) begin @(posedge clk); n++; end
    if (n >= 2000) chk(0, "watchdog", n, 0);
  endtask

  task automatic check_frame(input logic [1:0] idx, input logic [4:0] rg, input logic [7:0] d);
    logic [15:0] exp_w;
    logic [1:0] exp_cs;
    exp_w  = {2'b10, 1'b1, rg, d};
    exp_cs = (idx == 0) ? 2'b01 : 2'b10;
    chk(cap == exp_w, "R1 word", cap, exp_w);
    chk(rises == 16, "R2 rising edges", rises, 16);
    chk(bad_order == 0, "R3 data moved with clock high", bad_order, 0);
    chk(cs_seen == exp_cs, "R5 select used", cs_seen, exp_cs);
    chk(both_low == 0, "R5 both selects low", both_low, 0);
    chk(min_gap >= S, "R7 min gap", min_gap, S);
    chk(busy_cnt == 51 * S, "R7 busy length", busy_cnt, 51 * S);
    chk(end_gap == S, "R6 release interval", end_gap, S);
    chk(sdata && sclk && cs_n == 2'b11, "R6 lines high after word", {sdata, sclk, cs_n}, 4'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk(ready && !busy && sdata && sclk && cs_n == 2'b11, "R9 reset state",
        {ready, busy, sdata, sclk, cs_n}, 6'b101111);
    rst_ni = 1;

    for (int i = 0; i < NVEC; i++) begin
      offer(VEC[i][14:13], VEC[i][12:8], VEC[i][7:0]);
      // R8 busy and not ready right after acceptance
      chk(busy && !ready, "R8 busy after take", {busy, ready}, 2'b10);
      // R4 lines still high during first settle interval
      chk(sdata && sclk && cs_n == 2'b11, "R4 pre-select high", {sdata, sclk, cs_n}, 4'hF);
      wait_done();
      check_frame(VEC[i][14:13], VEC[i][12:8], VEC[i][7:0]);
    end

    // R8 requests during a word are ignored
    offer(2'd1, 5'h07, 8'h3C);
    repeat (5) @(negedge clk);
    req_valid = 1; req_idx = 0; req_reg = 5'h1E; req_data = 8'hC3;
    repeat (20) @(negedge clk);
    req_valid = 0;
    wait_done();
    check_frame(2'd1, 5'h07, 8'h3C);
    begin
      int fs;
      fs = frames_started;
      repeat (10) @(negedge clk);
      #1;
      chk(!busy && frames_started == fs, "R8 no extra word", frames_started, fs);
    end

    // R9 reset in the middle of a word
    offer(2'd0, 5'h05, 8'h00);
    repeat (40) @(negedge clk);
    rst_ni = 0;
    #1;
    chk(ready && !busy && sdata && sclk && cs_n == 2'b11, "R9 mid-word reset",
        {ready, busy, sdata, sclk, cs_n}, 6'b101111);
    @(negedge clk);
    rst_ni = 1;
    offer(2'd3, 5'h11, 8'h96);
    wait_done();
    check_frame(2'd3, 5'h11, 8'h96);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule